// File: doc/BRIEF.md
# Multi-Mode Event Counter Channel

This block is one 32-bit event counter channel. Four debounced, clock-synchronous input signals arrive on a shared bus. A 2-bit select picks the signal whose rising edges are counted. A second 2-bit select picks a companion ("mapped") signal. That signal is given one job: it qualifies counting by its level, it takes one off the count on each of its rising edges, or its rising edge copies the count into the readout register. It can also be given no job at all.

The channel runs in one of three modes:

- **Wrap-around totalizer**: the count rolls over at the configured width.
- **Clear-on-read**: reading the low half returns the count from just before the read, and the counter then restarts from zero.
- **Saturating counter**: the count holds at its limits.

A width control picks a 16-bit or a 32-bit count. A scan-start pulse zeroes the count. A per-scan latch strobe copies the count into the readout register.

Software reads the count 16 bits at a time. Reading the low half freezes a copy of all 32 bits, and a later high-half read returns the upper half of that same copy.

Top module: `evt_count_channel`

## Requirements
- R1: After reset the count is 0, `rd_data` is 0 and `scan_word` is 0.
- R2: Each rising edge of `sig_in[cnt_sel]` adds exactly one to the count. Edges on unselected signals and a level held high for many cycles add nothing more.
- R3: In wrap mode (`mode`=00) with `width16`=1, the count wraps between 0xFFFF and 0 and its upper 16 bits stay 0. With `width16`=0 it wraps between 0xFFFFFFFF and 0.
- R4: In saturating mode (`mode`=10), an increment at the maximum (0xFFFF or 0xFFFFFFFF) leaves the count at the maximum. A decrement at 0 leaves it at 0.
- R5: With `map_fn`=01 (gate), count edges are counted only while `sig_in[map_sel]` is high.
- R6: With `map_fn`=10 (decrement), each rising edge of `sig_in[map_sel]` subtracts one. An increment and a decrement in the same cycle leave the count unchanged.
- R7: A `scan_start` pulse sets the count to 0. It wins over a count edge in the same cycle.
- R8: A `rd_lo` pulse puts the low 16 bits of the current count on `rd_data` one cycle later and freezes all 32 bits. A later `rd_hi` pulse puts the upper 16 bits of that frozen copy on `rd_data` one cycle later, even if the count has changed in between.
- R9: In clear-on-read mode (`mode`=01), `rd_lo` returns the count from just before the read and sets the count to 0. A count edge in the same cycle is lost.
- R10: When `map_fn` is not 11, a `scan_latch` pulse copies the count into `scan_word`. When `map_fn`=11 (latch), a rising edge of `sig_in[map_sel]` copies it instead, and `scan_latch` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 4 | Debounced, synchronous counter input signals |
| cnt_sel | input | 2 | Index of the signal to count |
| map_sel | input | 2 | Index of the companion (mapped) signal |
| map_fn | input | 2 | Job of the mapped signal: 00 none, 01 gate, 10 decrement, 11 latch |
| mode | input | 2 | 00 wrap, 01 clear-on-read, 10 saturate, 11 behaves as wrap |
| width16 | input | 1 | 1 selects a 16-bit count, 0 selects a 32-bit count |
| scan_start | input | 1 | Pulse that zeroes the count |
| scan_latch | input | 1 | Per-scan strobe that copies the count into `scan_word` |
| rd_lo | input | 1 | Low-half read strobe; freezes the 32-bit copy |
| rd_hi | input | 1 | High-half read strobe; returns the upper half of the frozen copy |
| rd_data | output | 16 | Registered read data |
| scan_word | output | 32 | Readout register |

## Verification
The counted signal is driven as single-cycle pulses, as a level held high for several cycles, and alongside pulses on unselected signals. Together these separate true edge counting from level counting and from a wrong select.

Decrement pulses starting from zero drive the count to the 16-bit and 32-bit maximums without long runs. Pulses in the same cycle then exercise increment-versus-decrement cancellation, clear-versus-count priority and read-versus-count priority.

A count change between a low read and a high read shows whether the high half comes from the frozen copy or from the live count. Latch strobes given with and without the mapped latch job show which source is allowed to update the readout register.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_WRAP = 2'b00,
        MODE_COR  = 2'b01,
        MODE_SAT  = 2'b10,
        MODE_ALT  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        MAP_NONE  = 2'b00,
        MAP_GATE  = 2'b01,
        MAP_DEC   = 2'b10,
        MAP_LATCH = 2'b11
    } map_fn_e;

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
    parameter int N_SIG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] lvl_i,
    output logic [N_SIG-1:0] rise_o
);

    typedef struct packed {
        logic [N_SIG-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A rise can never be reported in two consecutive cycles (R2)
    for (genvar i = 0; i < N_SIG; i++) begin : g_chk
        assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_rise_i,
    input  logic             map_lvl_i,
    input  logic             map_rise_i,
    input  map_fn_e          map_fn_i,
    input  cnt_mode_e        mode_i,
    input  logic             width16_i,
    input  logic             scan_start_i,
    input  logic             rd_lo_i,
    output logic [CNT_W-1:0] count_o
);

    localparam int UP_W = CNT_W - HALF_W;
    localparam logic [CNT_W-1:0] MASK_NARROW = {{UP_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [CNT_W-1:0] MASK_WIDE   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE         = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_state_t;

    core_state_t      st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic             gate_ok;
    logic             inc;
    logic             dec;
    logic             clear;
    logic             sat;

    always_comb begin
        st_d    = st_q;
        mask    = width16_i ? MASK_NARROW : MASK_WIDE;
        cur     = st_q.count & mask;
        gate_ok = (map_fn_i != MAP_GATE) || map_lvl_i;
        inc     = cnt_rise_i && gate_ok;
        dec     = (map_fn_i == MAP_DEC) && map_rise_i;
        clear   = scan_start_i || ((mode_i == MODE_COR) && rd_lo_i);
        sat     = (mode_i == MODE_SAT);

        if (clear) begin
            st_d.count = '0;
        end else if (inc && !dec) begin
            if (sat && (cur == mask)) st_d.count = cur;
            else                      st_d.count = (cur + ONE) & mask;
        end else if (dec && !inc) begin
            if (sat && (cur == '0))   st_d.count = cur;
            else                      st_d.count = (cur - ONE) & mask;
        end else begin
            st_d.count = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    assert_scan_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start_i |=> (count_o == '0));

    assert_cor_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_COR && rd_lo_i) |=> (count_o == '0));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        width16_i |=> (count_o[CNT_W-1:HALF_W] == '0));

    assert_sat_hold_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && inc && !dec && !clear && cur == mask) |=> (count_o == $past(mask)));

    assert_sat_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && dec && !inc && !clear && cur == '0) |=> (count_o == '0));

    assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && !clear) |=> (count_o == $past(cur)));

endmodule

// File: rtl/evt_read_port.sv
module evt_read_port
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    input  logic              scan_latch_i,
    input  logic              map_rise_i,
    input  map_fn_e           map_fn_i,
    output logic [HALF_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  scan_word_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  snap;
        logic [HALF_W-1:0] rd_data;
        logic [CNT_W-1:0]  scan_word;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      latch_evt;

    always_comb begin
        st_d      = st_q;
        latch_evt = (map_fn_i == MAP_LATCH) ? map_rise_i : scan_latch_i;

        if (rd_lo_i) begin
            st_d.snap    = count_i;
            st_d.rd_data = count_i[HALF_W-1:0];
        end else if (rd_hi_i) begin
            st_d.rd_data = st_q.snap[CNT_W-1:CNT_W-HALF_W];
        end

        if (latch_evt) st_d.scan_word = count_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o   = st_q.rd_data;
    assign scan_word_o = st_q.scan_word;

    assert_snap_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i |=> (st_q.snap == $past(count_i)) && (rd_data_o == $past(count_i[HALF_W-1:0])));

    assert_hi_from_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && !rd_lo_i) |=> (rd_data_o == $past(st_q.snap[CNT_W-1:CNT_W-HALF_W])));

    assert_map_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (map_fn_i == MAP_LATCH && map_rise_i) |=> (scan_word_o == $past(count_i)));

    assert_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (map_fn_i == MAP_LATCH && !map_rise_i) |=> $stable(scan_word_o));

endmodule

// File: rtl/evt_count_channel.sv
module evt_count_channel
    import evt_cnt_pkg::*;
#(
    parameter int N_SIG  = 4,
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16,
    localparam int SEL_W = $clog2(N_SIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SIG-1:0]  sig_in,
    input  logic [SEL_W-1:0]  cnt_sel,
    input  logic [SEL_W-1:0]  map_sel,
    input  logic [1:0]        map_fn,
    input  logic [1:0]        mode,
    input  logic              width16,
    input  logic              scan_start,
    input  logic              scan_latch,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [HALF_W-1:0] rd_data,
    output logic [CNT_W-1:0]  scan_word
);

    logic [N_SIG-1:0] rise;
    logic [CNT_W-1:0] count;
    logic             cnt_rise;
    logic             map_rise;
    logic             map_lvl;
    map_fn_e          fn;
    cnt_mode_e        md;

    always_comb begin
        cnt_rise = rise[cnt_sel];
        map_rise = rise[map_sel];
        map_lvl  = sig_in[map_sel];
        fn       = map_fn_e'(map_fn);
        md       = cnt_mode_e'(mode);
    end

    evt_edge_det #(.N_SIG(N_SIG)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sig_in),
        .rise_o (rise)
    );

    evt_count_core #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_rise_i   (cnt_rise),
        .map_lvl_i    (map_lvl),
        .map_rise_i   (map_rise),
        .map_fn_i     (fn),
        .mode_i       (md),
        .width16_i    (width16),
        .scan_start_i (scan_start),
        .rd_lo_i      (rd_lo),
        .count_o      (count)
    );

    evt_read_port #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_i      (count),
        .rd_lo_i      (rd_lo),
        .rd_hi_i      (rd_hi),
        .scan_latch_i (scan_latch),
        .map_rise_i   (map_rise),
        .map_fn_i     (fn),
        .rd_data_o    (rd_data),
        .scan_word_o  (scan_word)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && (scan_word == '0));

endmodule

// File: tb/sim_evt_count_channel.sv
`timescale 1ns/1ps
module sim_evt_count_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sig_in = '0;
    logic [1:0]  cnt_sel = '0, map_sel = 2'd1, map_fn = '0, mode = '0;
    logic        width16 = 1'b0, scan_start = 1'b0, scan_latch = 1'b0;
    logic        rd_lo = 1'b0, rd_hi = 1'b0;
    logic [15:0] rd_data;
    logic [31:0] scan_word;
    logic [3:0]  hold = '0;
    int          total = 0, fails = 0;

    always #2.5 clk = ~clk;

    evt_count_channel u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cnt_sel(cnt_sel),
        .map_sel(map_sel), .map_fn(map_fn), .mode(mode), .width16(width16),
        .scan_start(scan_start), .scan_latch(scan_latch), .rd_lo(rd_lo),
        .rd_hi(rd_hi), .rd_data(rd_data), .scan_word(scan_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus driven at a falling edge, released at the next.
    task automatic step(input logic [3:0] m, input logic lo, input logic hi,
                        input logic ss, input logic sl);
        @(negedge clk);
        sig_in = hold | m; rd_lo = lo; rd_hi = hi; scan_start = ss; scan_latch = sl;
        @(negedge clk);
        sig_in = hold; rd_lo = 0; rd_hi = 0; scan_start = 0; scan_latch = 0;
    endtask

    task automatic pulse(input int i, input int n);
        for (int k = 0; k < n; k++) step(4'b1 << i, 0, 0, 0, 0);
    endtask

    task automatic read32(output logic [31:0] v);
        step(0, 1, 0, 0, 0);
        v[15:0] = rd_data;
        step(0, 0, 1, 0, 0);
        v[31:16] = rd_data;
    endtask

    task automatic setup(input logic [1:0] md, input logic [1:0] fn, input logic w16);
        @(negedge clk);
        mode = md; map_fn = fn; width16 = w16; cnt_sel = 0; map_sel = 1; hold = 0; sig_in = 0;
        step(0, 0, 0, 1, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rd_data", {16'h0, rd_data}, 0);
        chk("R1 scan_word", scan_word, 0);
        read32(v);
        chk("R1 count", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        setup(2'b00, 2'b00, 0);
        pulse(0, 3);
        pulse(2, 2);
        read32(v);
        chk("R2 three edges, others ignored", v, 3);
        @(negedge clk); cnt_sel = 2; hold = 4'b0100; sig_in = hold;
        repeat (4) @(negedge clk);
        hold = 0; sig_in = 0;
        pulse(2, 1);
        read32(v);
        chk("R2 held level counts once", v, 5);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        setup(2'b00, 2'b10, 1);
        pulse(1, 1);
        read32(v);
        chk("R3 16-bit wrap down", v, 32'h0000FFFF);
        pulse(0, 1);
        read32(v);
        chk("R3 16-bit wrap up", v, 0);
        setup(2'b00, 2'b10, 0);
        pulse(1, 1);
        read32(v);
        chk("R3 32-bit wrap down", v, 32'hFFFFFFFF);
        pulse(0, 1);
        read32(v);
        chk("R3 32-bit wrap up", v, 0);
    endtask

    task automatic t_sat();
        logic [31:0] v;
        setup(2'b00, 2'b10, 1);
        pulse(1, 1);
        @(negedge clk); mode = 2'b10;
        pulse(0, 2);
        read32(v);
        chk("R4 hold at 0xFFFF", v, 32'h0000FFFF);
        pulse(1, 1);
        read32(v);
        chk("R4 dec below max", v, 32'h0000FFFE);
        setup(2'b10, 2'b10, 0);
        pulse(1, 1);
        read32(v);
        chk("R4 hold at zero", v, 0);
        @(negedge clk); mode = 2'b00;
        pulse(1, 1);
        @(negedge clk); mode = 2'b10;
        pulse(0, 1);
        read32(v);
        chk("R4 hold at 0xFFFFFFFF", v, 32'hFFFFFFFF);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        setup(2'b00, 2'b01, 0);
        pulse(0, 2);
        read32(v);
        chk("R5 gate low blocks", v, 0);
        @(negedge clk); hold = 4'b0010; sig_in = hold;
        pulse(0, 2);
        read32(v);
        chk("R5 gate high counts", v, 2);
        @(negedge clk); hold = 0; sig_in = 0;
    endtask

    task automatic t_dec();
        logic [31:0] v;
        setup(2'b00, 2'b10, 0);
        pulse(0, 3);
        pulse(1, 1);
        read32(v);
        chk("R6 decrement", v, 2);
        step(4'b0011, 0, 0, 0, 0);
        read32(v);
        chk("R6 inc and dec cancel", v, 2);
    endtask

    task automatic t_scan_clear();
        logic [31:0] v;
        setup(2'b00, 2'b00, 0);
        pulse(0, 4);
        step(4'b0001, 0, 0, 1, 0);
        read32(v);
        chk("R7 clear wins over edge", v, 0);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        setup(2'b00, 2'b10, 0);
        pulse(1, 1);
        step(0, 1, 0, 0, 0);
        chk("R8 low half", {16'h0, rd_data}, 32'hFFFF);
        pulse(0, 1);
        step(0, 0, 1, 0, 0);
        chk("R8 high half from snapshot", {16'h0, rd_data}, 32'hFFFF);
        read32(v);
        chk("R8 live count moved on", v, 0);
    endtask

    task automatic t_cor();
        logic [31:0] v;
        setup(2'b01, 2'b00, 0);
        pulse(0, 3);
        read32(v);
        chk("R9 pre-clear value", v, 3);
        read32(v);
        chk("R9 restart from zero", v, 0);
        pulse(0, 1);
        step(4'b0001, 1, 0, 0, 0);
        chk("R9 read with edge returns old", {16'h0, rd_data}, 1);
        read32(v);
        chk("R9 edge lost on clear", v, 0);
    endtask

    task automatic t_latch();
        setup(2'b00, 2'b00, 0);
        pulse(0, 5);
        step(0, 0, 0, 0, 1);
        chk("R10 strobe latches", scan_word, 5);
        pulse(0, 2);
        chk("R10 no strobe keeps", scan_word, 5);
        @(negedge clk); map_fn = 2'b11; map_sel = 3;
        step(0, 0, 0, 0, 1);
        chk("R10 strobe ignored in latch job", scan_word, 5);
        step(4'b1000, 0, 0, 0, 0);
        chk("R10 mapped edge latches", scan_word, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_sat();
        t_gate();
        t_dec();
        t_scan_clear();
        t_snapshot();
        t_cor();
        t_latch();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #100000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule